// File: doc/BRIEF.md
# Secondary Interrupt Source Controller

This block gathers the event inputs of one functional module, up to 24 of them, and turns selected edges into latched pending bits. One edge-select array, shared by both output lines, decides for every source whether a rising edge, a falling edge, both or neither is captured. Each captured event sets the source's pending bit in two independent status banks, one per output line. Each bank has its own mask. An active-low interrupt line is driven low while any unmasked pending bit is set in its bank.

Software reaches everything through a plain byte-wide register port. The port has one address, a write strobe, a read strobe and registered read data. The address space is split into eight-byte windows, selected by address bits [5:3]. Multi-byte fields are little-endian. Pending bits are cleared in one of two ways, chosen by a control bit. In one mode, reading a status byte clears what it returned. In the other, writing ones to a status byte clears those bits. A second event on a source that is already pending is held back in a one-deep buffer and reappears when the bit is cleared. A test window lets software force pending bits.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset both interrupt lines are high. Every mask bit of a real source is 1, every edge-select bit is 0, every status bit is 0 and the control byte (address 0x30) reads 0.
- R2: The edge-select window starts at address 0x00. Source i uses bits 2i+1 (rising) and 2i (falling) of that little-endian field, which is bit pair (i mod 4)*2 of byte i/4. An edge is seen when the source input differs from its value one clock earlier and the matching enable bit is 1.
- R3: A source whose two edge-select bits are both 0 never sets a status bit, whatever it does.
- R4: A captured event sets the source's bit in both status banks: line A at 0x08 and line B at 0x18. A mask bit of 1 (masks at 0x10 for A and 0x20 for B) blocks that source from its line only. Each line output is low exactly while its bank holds a set status bit whose mask bit is 0.
- R5: With control bit 0 set to 1, a read of a status byte returns the pending bits and clears them. Writes to status bytes are then ignored.
- R6: With control bit 0 at 0, a read leaves status unchanged. Writing a byte to a status address clears the bits where that byte holds 1. A set status bit stays set until one of these two clearing accesses hits it.
- R7: An event on a source whose bit in a bank is already pending is remembered once. When that bit is cleared it stays set, and a second clear is needed to empty it.
- R8: If a new event and a clearing access hit the same status bit in the same cycle, the bit is still set afterwards.
- R9: Writing ones to the test-set window (0x28 onward, same byte layout as status) sets those status bits in both banks on the next clock edge. The window reads as 0.
- R10: Status and mask bits at or above the source count, and edge-select bits at or above twice the source count, read as 0 and ignore writes.
- R11: Status and mask fields are little-endian: byte k at offset k holds sources 8k to 8k+7.
- R12: Read data is registered. It shows the addressed byte in the cycle after the read strobe and is 0 in every cycle that follows no read. Unused addresses (window 0x38 and bytes past a field's end) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Event source levels, synchronous to clk |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_rd | input | 1 | Read strobe for the register port |
| reg_addr | input | 6 | Byte address: [5:3] window, [2:0] byte lane |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_a_n | output | 1 | Interrupt line A, active low |
| irq_b_n | output | 1 | Interrupt line B, active low |

## Verification
The assertions assume that src_i is already synchronous to clk. They also assume that a cycle with neither strobe is a true idle for the register port, so a pending bit may only fall after an access. The test-set check assumes the source count is at least eight, which holds for the default of 18. The bench drives the sources and all port inputs only on the falling clock edge, from one sequential process. Its random phase draws addresses only from the 6-bit space and toggles sources sparsely, so that edges, collisions and buffered events all occur.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int ADDR_W   = 6;
  localparam int WIN_BYTES = 8;
  localparam int WIN_W    = WIN_BYTES * 8;
  localparam int MAX_SRC  = 24;

  typedef enum logic [2:0] {
    WIN_EDGE  = 3'd0,
    WIN_STA_A = 3'd1,
    WIN_MSK_A = 3'd2,
    WIN_STA_B = 3'd3,
    WIN_MSK_B = 3'd4,
    WIN_TEST  = 3'd5,
    WIN_CTRL  = 3'd6
  } win_e;

  // place a byte into its lane of a window-wide vector
  function automatic logic [WIN_W-1:0] lane_fill(input logic [2:0] lane,
                                                 input logic [7:0] val);
    return WIN_W'(val) << {lane, 3'b000};
  endfunction

  function automatic logic [WIN_W-1:0] lane_sel(input logic [2:0] lane);
    return WIN_W'(8'hFF) << {lane, 3'b000};
  endfunction
endpackage

// File: rtl/sic_edge_det.sv
module sic_edge_det #(
  parameter int NUM_SRC = 18,
  localparam int CFG_W  = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [CFG_W-1:0]   cfg_i,
  output logic [NUM_SRC-1:0] evt_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic prev_q;
    logic rise_en, fall_en;
    assign rise_en = cfg_i[2*i+1];
    assign fall_en = cfg_i[2*i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= src_i[i];
    end

    assign evt_o[i] = (rise_en &  src_i[i] & ~prev_q) |
                      (fall_en & ~src_i[i] &  prev_q);
  end
endmodule

// File: rtl/sic_status_bank.sv
module sic_status_bank #(
  parameter int NUM_SRC = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] sta_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic pend_q, hold_q, clr_eff;
    assign clr_eff = clr_i[i] & pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        hold_q <= 1'b0;
      end else if (clr_eff) begin
        // a held event or a fresh one keeps the bit alive
        pend_q <= hold_q | evt_i[i];
        hold_q <= hold_q & evt_i[i];
      end else begin
        pend_q <= pend_q | evt_i[i];
        hold_q <= hold_q | (pend_q & evt_i[i]);
      end
    end

    assign sta_o[i] = pend_q;
  end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [5:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_a_n,
  output logic               irq_b_n
);
  localparam int EDGE_W = 2 * NUM_SRC;

  logic [2:0]         win;
  logic [2:0]         lane;
  logic [WIN_W-1:0]   wfill, wsel;
  logic [EDGE_W-1:0]  edge_q;
  logic               cor_q;
  logic [NUM_SRC-1:0] evt, tst_vec, evt_all;
  logic [NUM_SRC-1:0] sta_l [2];
  logic [NUM_SRC-1:0] msk_l [2];
  logic [1:0]         irq_n;
  logic [WIN_W-1:0]   rd_win;
  logic [7:0]         rd_byte, rdata_q;
  logic [NUM_SRC-1:0] sta_a, sta_b, msk_a, msk_b;

  assign win   = reg_addr[5:3];
  assign lane  = reg_addr[2:0];
  assign wfill = lane_fill(lane, reg_wdata);
  assign wsel  = lane_sel(lane);

  // shared edge-select array and control bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      cor_q  <= 1'b0;
    end else if (reg_wr) begin
      if (win == WIN_EDGE)
        edge_q <= (edge_q & ~wsel[EDGE_W-1:0]) | wfill[EDGE_W-1:0];
      if (win == WIN_CTRL && lane == 3'd0)
        cor_q <= reg_wdata[0];
    end
  end

  sic_edge_det #(.NUM_SRC(NUM_SRC)) edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .cfg_i (edge_q),
    .evt_o (evt)
  );

  assign tst_vec = (reg_wr && win == WIN_TEST) ? wfill[NUM_SRC-1:0] : '0;
  assign evt_all = evt | tst_vec;

  for (genvar l = 0; l < 2; l++) begin : g_line
    localparam logic [2:0] STA_WIN = 3'(1 + 2*l);
    localparam logic [2:0] MSK_WIN = 3'(2 + 2*l);
    logic [NUM_SRC-1:0] msk_q, clr, sta;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        msk_q <= '1;
      else if (reg_wr && win == MSK_WIN)
        msk_q <= (msk_q & ~wsel[NUM_SRC-1:0]) | wfill[NUM_SRC-1:0];
    end

    always_comb begin
      clr = '0;
      if (cor_q) begin
        if (reg_rd && win == STA_WIN) clr = sta & wsel[NUM_SRC-1:0];
      end else begin
        if (reg_wr && win == STA_WIN) clr = wfill[NUM_SRC-1:0];
      end
    end

    sic_status_bank #(.NUM_SRC(NUM_SRC)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_all),
      .clr_i (clr),
      .sta_o (sta)
    );

    assign sta_l[l] = sta;
    assign msk_l[l] = msk_q;
    assign irq_n[l] = ~|(sta & ~msk_q);
  end

  assign sta_a = sta_l[0];
  assign sta_b = sta_l[1];
  assign msk_a = msk_l[0];
  assign msk_b = msk_l[1];

  always_comb begin
    rd_win = '0;
    case (win)
      WIN_EDGE:  rd_win = WIN_W'(edge_q);
      WIN_STA_A: rd_win = WIN_W'(sta_a);
      WIN_MSK_A: rd_win = WIN_W'(msk_a);
      WIN_STA_B: rd_win = WIN_W'(sta_b);
      WIN_MSK_B: rd_win = WIN_W'(msk_b);
      WIN_CTRL:  rd_win[0] = cor_q;
      default:   rd_win = '0;
    endcase
  end
  assign rd_byte = rd_win[{lane, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 8'h00;
    else        rdata_q <= reg_rd ? rd_byte : 8'h00;
  end

  assign reg_rdata = rdata_q;
  assign irq_a_n   = irq_n[0];
  assign irq_b_n   = irq_n[1];
endmodule

// File: rtl/sec_irq_ctrl_chk.sv
module sec_irq_ctrl_chk #(
  parameter int NUM_SRC = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [5:0]           reg_addr,
  input logic [7:0]           reg_wdata,
  input logic [7:0]           reg_rdata,
  input logic [2*NUM_SRC-1:0] edge_cfg,
  input logic [NUM_SRC-1:0]   sta_a,
  input logic [NUM_SRC-1:0]   sta_b,
  input logic [NUM_SRC-1:0]   msk_a,
  input logic [NUM_SRC-1:0]   msk_b,
  input logic                 irq_a_n,
  input logic                 irq_b_n
);
  localparam logic [63:0] VALID = (64'd1 << NUM_SRC) - 64'd1;
  localparam logic [7:0]  VALID0 = VALID[7:0];

  logic [63:0] pad_a, pad_b;
  logic        test_wr;
  assign pad_a   = 64'(sta_a);
  assign pad_b   = 64'(sta_b);
  assign test_wr = reg_wr && (reg_addr[5:3] == 3'd5);

  AST_MASKED_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_a) |-> irq_a_n); // R4
  AST_MASKED_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_b) |-> irq_b_n); // R4
  AST_NO_EDGE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cfg == '0 && !test_wr) |=> ((sta_a & ~$past(sta_a)) == '0)); // R3
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !reg_rd) |=> ((sta_a & $past(sta_a)) == $past(sta_a))); // R6
  AST_TEST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h28) |=>
      ((pad_a[7:0] & pad_b[7:0] & $past(reg_wdata) & VALID0) == ($past(reg_wdata) & VALID0))); // R9
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == 8'h00)); // R12
endmodule

bind sec_irq_ctrl sec_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .edge_cfg  (edge_q),
  .sta_a     (sta_a),
  .sta_b     (sta_b),
  .msk_a     (msk_a),
  .msk_b     (msk_b),
  .irq_a_n   (irq_a_n),
  .irq_b_n   (irq_b_n)
);

// File: tb/sec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sec_irq_ctrl_tb_top;
  localparam int NS = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          irq_a_n, irq_b_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [2*NS-1:0] m_edge;
  logic [NS-1:0]   m_sta [2];
  logic [NS-1:0]   m_buf [2];
  logic [NS-1:0]   m_msk [2];
  logic            m_cor;
  logic [NS-1:0]   m_srcq;
  logic [NS-1:0]   cur_src;

  sec_irq_ctrl #(.NUM_SRC(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [5:0] a);
    logic [63:0] v;
    case (a[5:3])
      3'd0: v = 64'(m_edge);
      3'd1: v = 64'(m_sta[0]);
      3'd2: v = 64'(m_msk[0]);
      3'd3: v = 64'(m_sta[1]);
      3'd4: v = 64'(m_msk[1]);
      3'd6: v = 64'(m_cor);
      default: v = '0;
    endcase
    return v[{a[2:0], 3'b000} +: 8];
  endfunction

  task automatic model_step(input logic w, input logic r, input logic [5:0] a,
                            input logic [7:0] d, input logic [NS-1:0] s);
    logic [NS-1:0] ev, clr, nsta, nbuf;
    logic [63:0] fill, sel;
    fill = 64'(d) << (a[2:0] * 8);
    sel  = 64'hFF << (a[2:0] * 8);
    for (int i = 0; i < NS; i++)
      ev[i] = (s[i] & ~m_srcq[i] & m_edge[2*i+1]) | (~s[i] & m_srcq[i] & m_edge[2*i]);
    if (w && a[5:3] == 3'd5) ev = ev | fill[NS-1:0];
    for (int l = 0; l < 2; l++) begin
      clr = '0;
      if (m_cor && r && a[5:3] == 3'(1 + 2*l)) clr = m_sta[l] & sel[NS-1:0];
      if (!m_cor && w && a[5:3] == 3'(1 + 2*l)) clr = fill[NS-1:0];
      for (int i = 0; i < NS; i++) begin
        if (clr[i] && m_sta[l][i]) begin
          nsta[i] = m_buf[l][i] | ev[i];
          nbuf[i] = m_buf[l][i] & ev[i];
        end else begin
          nsta[i] = m_sta[l][i] | ev[i];
          nbuf[i] = m_buf[l][i] | (m_sta[l][i] & ev[i]);
        end
      end
      m_sta[l] = nsta;
      m_buf[l] = nbuf;
      if (w && a[5:3] == 3'(2 + 2*l))
        m_msk[l] = (m_msk[l] & ~sel[NS-1:0]) | fill[NS-1:0];
    end
    if (w && a[5:3] == 3'd0)
      m_edge = (m_edge & ~sel[2*NS-1:0]) | fill[2*NS-1:0];
    if (w && a == 6'h30) m_cor = d[0];
    m_srcq = s;
  endtask

  // one clock: drive at falling edge, check at the next falling edge
  task automatic tick(input string req, input logic w, input logic r, input logic [5:0] a,
                      input logic [7:0] d, input logic [NS-1:0] s, output logic [7:0] got);
    logic [7:0] exp_rd;
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; src_i = s;
    cur_src = s;
    exp_rd = r ? model_read(a) : 8'h00;
    model_step(w, r, a, d, s);
    @(posedge clk);
    @(negedge clk);
    got = reg_rdata;
    chk({req, " rdata"}, reg_rdata, exp_rd);
    chk("R4 irq_a_n", {7'b0, irq_a_n}, {7'b0, ~|(m_sta[0] & ~m_msk[0])});
    chk("R4 irq_b_n", {7'b0, irq_b_n}, {7'b0, ~|(m_sta[1] & ~m_msk[1])});
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] g;
    tick("R12", 1'b1, 1'b0, a, d, cur_src, g);
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] g;
    tick(req, 1'b0, 1'b1, a, 8'h00, cur_src, g);
    chk(req, g, exp);
  endtask

  task automatic src(input logic [NS-1:0] s);
    logic [7:0] g;
    tick("R2", 1'b0, 1'b0, 6'h00, 8'h00, s, g);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'd20240611));
    m_edge = '0; m_sta[0] = '0; m_sta[1] = '0; m_buf[0] = '0; m_buf[1] = '0;
    m_msk[0] = '1; m_msk[1] = '1; m_cor = 1'b0; m_srcq = '0; cur_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_a_n", {7'b0, irq_a_n}, 8'h01);
    chk("R1 irq_b_n", {7'b0, irq_b_n}, 8'h01);
    rd("R1 mask A byte0", 6'h10, 8'hFF);
    rd("R10 mask A top byte", 6'h12, 8'h03);
    rd("R1 edge byte0", 6'h00, 8'h00);
    rd("R1 control", 6'h30, 8'h00);

    // R2 rising capture on source 5, unmask on line A only
    wr(6'h01, 8'h08);
    wr(6'h10, 8'hDF);
    src(18'h00020);
    chk("R2 irq_a_n low", {7'b0, irq_a_n}, 8'h00);
    chk("R4 irq_b_n masked", {7'b0, irq_b_n}, 8'h01);
    rd("R11 status A byte0", 6'h08, 8'h20);
    rd("R4 status B byte0", 6'h18, 8'h20);
    // R2 falling capture on source 2
    wr(6'h00, 8'h10);
    src(18'h00024);
    src(18'h00020);
    rd("R2 falling", 6'h08, 8'h24);

    // R3 source 9 with no edge select
    src(18'h00220);
    src(18'h00020);
    rd("R3 no latch", 6'h09, 8'h00);

    // R6 write-one-to-clear
    rd("R6 read keeps", 6'h08, 8'h24);
    wr(6'h08, 8'h24);
    rd("R6 cleared", 6'h08, 8'h00);
    chk("R6 irq_a_n", {7'b0, irq_a_n}, 8'h01);

    // R7 buffered second event
    src(18'h00000);
    src(18'h00020);
    src(18'h00000);
    src(18'h00020);
    wr(6'h08, 8'h20);
    rd("R7 reappears", 6'h08, 8'h20);
    wr(6'h08, 8'h20);
    rd("R7 second clear", 6'h08, 8'h00);

    // R8 event and clear collide
    src(18'h00000);
    src(18'h00020);
    src(18'h00000);
    tick("R8", 1'b1, 1'b0, 6'h08, 8'h20, 18'h00020, g);
    rd("R8 event wins", 6'h08, 8'h20);
    wr(6'h08, 8'h20);
    rd("R8 then clears", 6'h08, 8'h00);

    // R5 clear-on-read
    wr(6'h30, 8'h01);
    rd("R5 control", 6'h30, 8'h01);
    src(18'h00000);
    src(18'h00020);
    rd("R5 read returns", 6'h08, 8'h20);
    rd("R5 read cleared", 6'h08, 8'h00);
    src(18'h00000);
    src(18'h00020);
    wr(6'h08, 8'h20);
    rd("R5 write ignored", 6'h08, 8'h20);

    // R9 test-set into both banks, R10 upper bits
    wr(6'h2A, 8'hFF);
    rd("R9 test A", 6'h0A, 8'h03);
    rd("R9 test B", 6'h1A, 8'h03);
    rd("R9 test reads 0", 6'h2A, 8'h00);
    wr(6'h12, 8'h00);
    rd("R10 mask low", 6'h12, 8'h00);
    wr(6'h12, 8'hFF);
    rd("R10 mask upper", 6'h12, 8'h03);
    wr(6'h04, 8'hFF);
    rd("R10 edge upper", 6'h04, 8'h0F);
    rd("R12 past edge field", 6'h05, 8'h00);
    rd("R12 unused window", 6'h38, 8'h00);
    src(cur_src);
    chk("R12 idle rdata", reg_rdata, 8'h00);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [NS-1:0] s;
      logic [5:0] a;
      logic w, r;
      int op;
      s  = cur_src ^ NS'($urandom & $urandom & $urandom);
      op = int'($urandom % 6);
      w  = (op == 1 || op == 3 || op == 5);
      r  = (op == 2 || op == 3);
      a  = 6'($urandom % 56);
      if ($urandom % 8 == 0) a = 6'h30;
      tick("R4 random", w, r, a, 8'($urandom), s, g);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule